// File: doc/BRIEF.md
# CAN Status and Interrupt Unit

This unit holds the status word of a CAN controller and decides when a status interrupt is raised. The protocol engine sends it one-cycle strobes for successful receive, successful transmit, a detected error with its type, and the 11-recessive-bit marker seen during bus-off recovery. The error-counter logic supplies three levels: bus-off, error warning and error passive. From these inputs the unit keeps an 8-bit status word. The low three bits of that word are a last-error code.

A status interrupt becomes pending only when hardware changes certain fields and the matching enable is set. Bus-off and warning changes are gated by the error-interrupt enable. Receive OK, transmit OK and last-error-code changes are gated by the status-change enable. A change of the passive bit never raises it, and neither does a CPU write. While it is pending, the interrupt identifier reads 16'h8000. A CPU read of the status word clears it, except when a new qualifying event lands in the same cycle.

The CPU reaches the unit through a small register port. Address 0 holds the status word and address 1 holds the interrupt identifier. Reads are combinational and writes take effect on the clock edge.

Top module: `can_status_unit`

## Requirements
- R1: After reset the status word reads 8'h00, irq_o is 0 and int_id_o is 16'h0000.
- R2: The status word is laid out as bit 7 bus-off, bit 6 warning, bit 5 passive, bit 4 receive OK, bit 3 transmit OK, and bits 2:0 last-error code. The code values are 0 none, 1 stuff, 2 form, 3 ack, 4 bit-1, 5 bit-0, 6 CRC and 7 no-event. An error strobe loads its code (1..6) at the next edge. A receive or transmit OK strobe without an error loads 0. An error wins over the recovery marker, and the recovery marker wins over OK.
- R3: A recovery marker strobe with no error strobe loads code 5 at the next edge.
- R4: Receive OK and transmit OK are set only by their strobes. A CPU write to address 0 loads bits 4:3 and is the only way to clear them. A strobe wins over a write in the same cycle.
- R5: Bits 7:5 follow the three level inputs one edge later. CPU writes to these bits have no effect.
- R6: A hardware change of bit 7 or bit 6 makes the interrupt pending when err_int_en is 1, and has no effect on it when err_int_en is 0.
- R7: A hardware change of bit 4, bit 3 or the last-error code makes the interrupt pending when stat_int_en is 1, and has no effect on it when stat_int_en is 0.
- R8: A change of bit 5 alone never makes the interrupt pending.
- R9: A CPU write never makes the interrupt pending.
- R10: irq_o reflects the pending flag. A read of address 1 returns 16'h8000 while it is pending and 16'h0000 otherwise. A read of address 0 returns the status word in bits 7:0 with zeros above.
- R11: A read of address 0 clears the pending flag at the next edge. If a qualifying event arrives in the same cycle, the flag stays set.
- R12: A CPU-written last-error code of 7 persists until the next error, recovery or OK strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_ok | input | 1 | Frame received successfully (strobe) |
| ev_tx_ok | input | 1 | Frame transmitted successfully (strobe) |
| ev_err | input | 1 | Protocol error detected (strobe) |
| ev_err_code | input | 3 | Error type for ev_err, 1..6 |
| ev_recov11 | input | 1 | 11 recessive bits seen in bus-off recovery (strobe) |
| lvl_bus_off | input | 1 | Bus-off level |
| lvl_warn | input | 1 | Error-warning level |
| lvl_passive | input | 1 | Error-passive level |
| err_int_en | input | 1 | Error interrupt enable |
| stat_int_en | input | 1 | Status-change interrupt enable |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | DATA_W | Read data |
| status_o | output | 8 | Status word |
| int_id_o | output | DATA_W | Interrupt identifier |
| irq_o | output | 1 | Status interrupt pending |

## Verification
The bench builds the unit with its default parameters: a 2-bit address, a 16-bit read path, the 16'h8000 identifier and a two-stage reset release. The two-bit address space reaches both registers and an unmapped address, so the bench can show that only a status read clears the flag. The width of 16 puts the identifier's top bit in the read data. The random phase mixes event strobes, level flips, enable changes and CPU traffic so that reads collide with events. The directed phase covers recovery, a write of code 7, passive-only changes and reset.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_IDLE  = 3'd7
  } lec_e;

  // bit order is the software-visible status layout
  typedef struct packed {
    logic bus_off;
    logic warn;
    logic passive;
    logic rx_ok;
    logic tx_ok;
    lec_e lec;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);

endpackage

// File: rtl/can_stat_rstsync.sv
module can_stat_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/can_stat_word.sv
module can_stat_word
  import can_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_rx_ok,
  input  logic        ev_tx_ok,
  input  logic        ev_err,
  input  logic [2:0]  ev_code,
  input  logic        ev_recov,
  input  logic        lvl_bus_off,
  input  logic        lvl_warn,
  input  logic        lvl_passive,
  input  logic        wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output stat_t       stat_q,
  output logic        err_chg,
  output logic        sc_chg
);
  stat_t stat_d;
  logic  stat_en;
  logic  hw_lec_vld;
  lec_e  hw_lec;

  // hardware code source, priority error > recovery > ok
  always_comb begin
    hw_lec_vld = 1'b1;
    hw_lec     = LEC_NONE;
    if (ev_err)                  hw_lec = lec_e'(ev_code);
    else if (ev_recov)           hw_lec = LEC_BIT0;
    else if (ev_rx_ok | ev_tx_ok) hw_lec = LEC_NONE;
    else                         hw_lec_vld = 1'b0;
  end

  always_comb begin
    stat_d         = stat_q;
    stat_d.bus_off = lvl_bus_off;
    stat_d.warn    = lvl_warn;
    stat_d.passive = lvl_passive;
    if (wr_en) begin
      stat_d.rx_ok = wr_data[4];
      stat_d.tx_ok = wr_data[3];
      stat_d.lec   = lec_e'(wr_data[2:0]);
    end
    if (ev_rx_ok)   stat_d.rx_ok = 1'b1;
    if (ev_tx_ok)   stat_d.tx_ok = 1'b1;
    if (hw_lec_vld) stat_d.lec   = hw_lec;
  end

  always_comb begin
    stat_en = wr_en | ev_rx_ok | ev_tx_ok | hw_lec_vld |
              (lvl_bus_off != stat_q.bus_off) |
              (lvl_warn    != stat_q.warn) |
              (lvl_passive != stat_q.passive);
    err_chg = (stat_d.bus_off != stat_q.bus_off) | (stat_d.warn != stat_q.warn);
    sc_chg  = (ev_rx_ok & ~stat_q.rx_ok) | (ev_tx_ok & ~stat_q.tx_ok) |
              (hw_lec_vld & (hw_lec != stat_q.lec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  // R2
  err_code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (stat_q.lec == lec_e'($past(ev_code))));

  // R3
  recov_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_recov && !ev_err) |=> (stat_q.lec == LEC_BIT0));

  // R4
  rx_ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q.rx_ok) |-> $past(wr_en));

  // R5
  passive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q.passive) |-> (stat_q.passive == $past(lvl_passive)));
endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic err_chg,
  input  logic sc_chg,
  input  logic err_en,
  input  logic sc_en,
  input  logic rd_clr,
  output logic pend_q
);
  logic set_c;
  logic pend_d;
  logic pend_en;

  always_comb begin
    set_c   = (err_chg & err_en) | (sc_chg & sc_en);
    pend_d  = set_c | (pend_q & ~rd_clr);
    pend_en = set_c | rd_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  // R11
  read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_c) |=> pend_q);

  // R11
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_c) |=> !pend_q);
endmodule

// File: rtl/can_stat_regif.sv
module can_stat_regif #(
  parameter int unsigned          ADDR_W    = 2,
  parameter int unsigned          DATA_W    = 16,
  parameter int unsigned          STAT_W    = 8,
  parameter logic [ADDR_W-1:0]    STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0]    ID_ADDR   = 1,
  parameter logic [DATA_W-1:0]    INT_ID    = 16'h8000
) (
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [STAT_W-1:0] cpu_wdata,
  input  logic [STAT_W-1:0] stat,
  input  logic              pend,
  output logic              wr_en,
  output logic [STAT_W-1:0] wr_data,
  output logic              rd_clr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] int_id
);
  logic stat_hit;
  logic id_hit;

  always_comb begin
    stat_hit = cpu_sel & (cpu_addr == STAT_ADDR);
    id_hit   = cpu_sel & (cpu_addr == ID_ADDR);
    wr_en    = stat_hit & cpu_wr;
    wr_data  = cpu_wdata;
    rd_clr   = stat_hit & ~cpu_wr;
    int_id   = pend ? INT_ID : '0;
    rdata    = '0;
    if (stat_hit & ~cpu_wr)    rdata[STAT_W-1:0] = stat;
    else if (id_hit & ~cpu_wr) rdata = int_id;
  end
endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
  import can_stat_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 2,
  parameter int unsigned       DATA_W     = 16,
  parameter logic [DATA_W-1:0] STAT_INT_ID = 16'h8000,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_ok,
  input  logic              ev_tx_ok,
  input  logic              ev_err,
  input  logic [2:0]        ev_err_code,
  input  logic              ev_recov11,
  input  logic              lvl_bus_off,
  input  logic              lvl_warn,
  input  logic              lvl_passive,
  input  logic              err_int_en,
  input  logic              stat_int_en,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] int_id_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = '0;
  localparam logic [ADDR_W-1:0] ID_ADDR   = ADDR_W'(1);

  logic              rst_sync_n;
  stat_t             stat_q;
  logic              err_chg;
  logic              sc_chg;
  logic              wr_en;
  logic [STAT_W-1:0] wr_data;
  logic              rd_clr;
  logic              pend_q;
  logic              hw_any;

  can_stat_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  can_stat_word u_word (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ev_rx_ok    (ev_rx_ok),
    .ev_tx_ok    (ev_tx_ok),
    .ev_err      (ev_err),
    .ev_code     (ev_err_code),
    .ev_recov    (ev_recov11),
    .lvl_bus_off (lvl_bus_off),
    .lvl_warn    (lvl_warn),
    .lvl_passive (lvl_passive),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .stat_q      (stat_q),
    .err_chg     (err_chg),
    .sc_chg      (sc_chg)
  );

  can_stat_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .err_chg (err_chg),
    .sc_chg  (sc_chg),
    .err_en  (err_int_en),
    .sc_en   (stat_int_en),
    .rd_clr  (rd_clr),
    .pend_q  (pend_q)
  );

  can_stat_regif #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_W    (STAT_W),
    .STAT_ADDR (STAT_ADDR),
    .ID_ADDR   (ID_ADDR),
    .INT_ID    (STAT_INT_ID)
  ) u_regif (
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .stat      (stat_q),
    .pend      (pend_q),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_clr    (rd_clr),
    .rdata     (cpu_rdata),
    .int_id    (int_id_o)
  );

  assign status_o = stat_q;
  assign irq_o    = pend_q;

  assign hw_any = ev_rx_ok | ev_tx_ok | ev_err | ev_recov11 |
                  (lvl_bus_off != status_o[7]) | (lvl_warn != status_o[6]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past(hw_any));
endmodule

// File: tb/test_can_status_unit.sv
`timescale 1ns/1ps
module test_can_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_rx_ok, ev_tx_ok, ev_err, ev_recov11;
  logic [2:0]  ev_err_code;
  logic        lvl_bus_off, lvl_warn, lvl_passive;
  logic        err_int_en, stat_int_en;
  logic        cpu_sel, cpu_wr;
  logic [1:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [15:0] cpu_rdata;
  logic [7:0]  status_o;
  logic [15:0] int_id_o;
  logic        irq_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [7:0]  exp_stat;
  logic        exp_pend;

  always #2 clk = ~clk;

  can_status_unit i_can_status_unit (
    .clk(clk), .rst_n(rst_n), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok),
    .ev_err(ev_err), .ev_err_code(ev_err_code), .ev_recov11(ev_recov11),
    .lvl_bus_off(lvl_bus_off), .lvl_warn(lvl_warn), .lvl_passive(lvl_passive),
    .err_int_en(err_int_en), .stat_int_en(stat_int_en), .cpu_sel(cpu_sel),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .status_o(status_o), .int_id_o(int_id_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected next {status, pending} from the requirements
  function automatic logic [8:0] model_next(input logic [7:0] s, input logic p);
    logic [7:0] n;
    logic hw_lec, errc, scc, setp, rdc;
    n = s;
    n[7] = lvl_bus_off; n[6] = lvl_warn; n[5] = lvl_passive;
    if (cpu_sel && cpu_wr && cpu_addr == 2'd0) n[4:0] = cpu_wdata[4:0];
    if (ev_rx_ok) n[4] = 1'b1;
    if (ev_tx_ok) n[3] = 1'b1;
    hw_lec = ev_err | ev_recov11 | ev_rx_ok | ev_tx_ok;
    if (ev_err)                   n[2:0] = ev_err_code;
    else if (ev_recov11)          n[2:0] = 3'd5;
    else if (ev_rx_ok | ev_tx_ok) n[2:0] = 3'd0;
    errc = (n[7] != s[7]) || (n[6] != s[6]);
    scc  = (ev_rx_ok && !s[4]) || (ev_tx_ok && !s[3]) || (hw_lec && n[2:0] != s[2:0]);
    setp = (errc && err_int_en) || (scc && stat_int_en);
    rdc  = cpu_sel && !cpu_wr && cpu_addr == 2'd0;
    return {n, setp || (p && !rdc)};
  endfunction

  task automatic idle_inputs();
    ev_rx_ok = 0; ev_tx_ok = 0; ev_err = 0; ev_recov11 = 0; ev_err_code = 3'd1;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 2'd0; cpu_wdata = 8'h00;
  endtask

  // caller sets inputs just after a falling edge
  task automatic cyc();
    logic [8:0] nx;
    #1;
    if (cpu_sel && !cpu_wr) begin
      if (cpu_addr == 2'd0)      chk("R10 status read", cpu_rdata, {8'h00, exp_stat});
      else if (cpu_addr == 2'd1) chk("R10 id read", cpu_rdata, exp_pend ? 16'h8000 : 16'h0000);
      else                       chk("R10 unmapped read", cpu_rdata, 16'h0000);
    end
    nx = model_next(exp_stat, exp_pend);
    @(posedge clk);
    exp_stat = nx[8:1];
    exp_pend = nx[0];
    #1;
    chk("R2 lec", {13'h0, status_o[2:0]}, {13'h0, exp_stat[2:0]});
    chk("R4 ok bits", {14'h0, status_o[4:3]}, {14'h0, exp_stat[4:3]});
    chk("R5 level bits", {13'h0, status_o[7:5]}, {13'h0, exp_stat[7:5]});
    chk("R7 pending", {15'h0, irq_o}, {15'h0, exp_pend});
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20211));
    idle_inputs();
    lvl_bus_off = 0; lvl_warn = 0; lvl_passive = 0;
    err_int_en = 1; stat_int_en = 1;
    exp_stat = 8'h00; exp_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 status", {8'h0, status_o}, 16'h0000);
    chk("R1 irq", {15'h0, irq_o}, 16'h0000);
    chk("R1 int id", int_id_o, 16'h0000);

    // R3 recovery marker loads 5
    ev_recov11 = 1; cyc();
    chk("R3 recovery code", {13'h0, status_o[2:0]}, 16'd5);
    chk("R10 id while pending", int_id_o, 16'h8000);
    // R11 read with colliding event keeps pending
    cpu_sel = 1; cpu_addr = 2'd0; ev_err = 1; ev_err_code = 3'd6; cyc();
    chk("R11 collide keeps", {15'h0, irq_o}, 16'h0001);
    cpu_sel = 1; cpu_addr = 2'd0; cyc();
    chk("R11 read clears", {15'h0, irq_o}, 16'h0000);
    // R9 cpu write never raises
    cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'hFF; cyc();
    chk("R9 write no irq", {15'h0, irq_o}, 16'h0000);
    chk("R5 write ignored", {13'h0, status_o[7:5]}, 16'h0000);
    // R12 code 7 persists
    repeat (5) cyc();
    chk("R12 idle keeps 7", {13'h0, status_o[2:0]}, 16'd7);
    ev_err = 1; ev_err_code = 3'd3; cyc();
    chk("R12 overwritten", {13'h0, status_o[2:0]}, 16'd3);
    cpu_sel = 1; cpu_addr = 2'd0; cyc();
    // R8 passive alone
    lvl_passive = 1; cyc();
    chk("R8 passive no irq", {15'h0, irq_o}, 16'h0000);
    // R6 bus-off with and without enable
    err_int_en = 0; lvl_bus_off = 1; cyc();
    chk("R6 disabled", {15'h0, irq_o}, 16'h0000);
    err_int_en = 1; lvl_bus_off = 0; cyc();
    chk("R6 enabled", {15'h0, irq_o}, 16'h0001);
    cpu_sel = 1; cpu_addr = 2'd1; cyc();
    cpu_sel = 1; cpu_addr = 2'd0; cyc();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ev_rx_ok    = (r[3:0] == 4'd0);
      ev_tx_ok    = (r[7:4] == 4'd0);
      ev_err      = (r[10:8] == 3'd0);
      ev_err_code = 3'd1 + 3'(r[13:11] % 6);
      ev_recov11  = (r[16:14] == 3'd0);
      if (r[20:17] == 4'd0) lvl_bus_off = ~lvl_bus_off;
      if (r[24:21] == 4'd0) lvl_warn    = ~lvl_warn;
      if (r[27:25] == 3'd0) lvl_passive = ~lvl_passive;
      if (r[31:28] == 4'd0) err_int_en  = ~err_int_en;
      if (r[31:28] == 4'd1) stat_int_en = ~stat_int_en;
      r = $urandom;
      cpu_sel   = r[1:0] == 2'd0;
      cpu_wr    = r[2] & r[3];
      cpu_addr  = r[5:4];
      cpu_wdata = r[13:6];
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule